// File: doc/BRIEF.md
# Host Bus Address Decoder

This block sits at the front of a small peripheral's host bus port and turns a raw host address cycle into something the register file behind it can use. It can hold the address with a transparent-low latch driven by the address strobe. It decides whether the device is selected within a 16-location window of I/O space, and it produces a two-bit register index. It also drives four byte-lane strobes and carries host data between a narrow host bus and the internal 32-bit word.

A separate, active-low data-port select bypasses the address window entirely. While it is asserted, the block reports a full 32-bit access to a fixed data register and ignores the byte enables. On a 16-bit host bus, address bit 1 picks which half of the internal word a host half-word maps to. This is word swapping. Bytes are never reordered within a half.

All decoded results are registered. They appear on the outputs one clock after the inputs that produced them are sampled.

Top module: `host_addr_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first sampled cycle, every output is zero.
- R2: With `dport_cs_n` high, `dev_hit` is 1 exactly when the effective address bits [15:4] equal `BASE_ADDR` and `aen` is 0. `reg_idx` is then effective address bits [3:2].
- R3: When `dev_hit` is 0, all four `lane_stb` bits are 0. This covers `aen` at 1 or a base mismatch.
- R4: With `dport_cs_n` low, `dev_hit` and `dport_acc` are 1 and `reg_idx` equals `DATA_IDX`, whatever the address and `aen` are. With `dport_cs_n` high, `dport_acc` is 0.
- R5: With `dport_cs_n` low, `lane_stb` is 4'b1111 whatever `be_n` is.
- R6: With `USE_LATCH`=1 and `ads_n` low, the effective address is `host_addr` of the same cycle. `lat_addr` shows the effective address.
- R7: With `ads_n` high, the effective address is the `host_addr` sampled at the last clock edge at which `ads_n` was low. Address changes while `ads_n` is high have no effect.
- R8: With `BUS_W`=32 and a normal hit, `lane_stb` is `~be_n`, `int_wdata` equals `host_wdata`, and `host_rdata` equals `int_rdata`.
- R9: With `BUS_W`=16, effective address bit 1 selects the half. A value of 0 means bits [15:0] and 1 means bits [31:16]. On a normal hit, `lane_stb` carries `~be_n[1:0]` in the two selected lanes and 0 in the others, and `be_n[3:2]` are ignored. `int_wdata` is `host_wdata` placed in both halves. `host_rdata` is the selected half of `int_rdata`.
- R10: Every output reflects the inputs sampled at the previous rising clock edge: a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | AW (16) | Host address |
| aen | input | 1 | Address-enable qualifier, must be 0 for a window hit |
| ads_n | input | 1 | Address strobe, latch transparent while low |
| dport_cs_n | input | 1 | Active-low data-port select |
| be_n | input | 4 | Active-low byte enables |
| host_wdata | input | BUS_W | Host write data |
| int_rdata | input | 32 | Internal read word |
| lat_addr | output | AW (16) | Effective (latched) address |
| dev_hit | output | 1 | Device selected |
| dport_acc | output | 1 | Data-port access in progress |
| reg_idx | output | 2 | Register index in the window |
| lane_stb | output | 4 | Active-high byte-lane strobes |
| int_wdata | output | 32 | Write data steered onto the internal word |
| host_rdata | output | BUS_W | Read data steered to the host |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench drives inputs on the falling edge and compares on the following falling edge, after one rising edge has registered them. The address latch adds no cycle of its own. It changes which address the result is computed from. The bench therefore carries its own model of the held address, updated after each compared cycle, and derives the expected effective address from it before predicting the result. Two instances, one per bus width, receive the same stimulus. This lets word steering and the full-width path be checked against each other's expectations.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int IDX_W    = 2;
    localparam int IDX_LSB  = 2;
    localparam int WIN_BITS = 4;

    typedef logic [LANES-1:0] lane_t;
    typedef logic [IDX_W-1:0] idx_t;

    // place a half-word strobe pair into the selected half of the lane vector
    function automatic lane_t half_lanes(input logic upper, input logic [1:0] pair);
        lane_t r;
        r = '0;
        if (upper) r[3:2] = pair;
        else       r[1:0] = pair;
        return r;
    endfunction
endpackage

// File: rtl/hbd_addr_latch.sv
module hbd_addr_latch #(
    parameter int AW        = 16,
    parameter bit USE_LATCH = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          ads_n_i,
    output logic [AW-1:0] addr_o
);
    generate
        if (USE_LATCH) begin : g_latch
            logic [AW-1:0] held_d, held_q;

            always_comb begin
                held_d = held_q;
                if (!ads_n_i) held_d = addr_i;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) held_q <= '0;
                else        held_q <= held_d;
            end

            // transparent while the strobe is low, held value otherwise
            assign addr_o = ads_n_i ? held_q : addr_i;

            AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                ads_n_i |=> $stable(held_q)); // R7
            AST_CAPTURE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !ads_n_i |=> (held_q == $past(addr_i))); // R6
        end else begin : g_flow
            logic unused_strobe;
            assign unused_strobe = ads_n_i ^ clk ^ rst_n;
            assign addr_o = addr_i;
        end
    endgenerate
endmodule

// File: rtl/hbd_decode.sv
module hbd_decode
    import hbd_pkg::*;
#(
    parameter int              AW        = 16,
    parameter logic [AW-5:0]   BASE_ADDR = 12'h030,
    parameter logic [IDX_W-1:0] DATA_IDX = 2'd3
) (
    input  logic [AW-1:0] addr_i,
    input  logic          aen_i,
    input  logic          dport_cs_n_i,
    output logic          hit_o,
    output logic          dport_o,
    output idx_t          idx_o
);
    localparam int TAG_W = AW - WIN_BITS;

    logic [TAG_W-1:0] tag;
    logic             win_match;
    logic [1:0]       unused_lo;

    assign tag       = addr_i[AW-1:WIN_BITS];
    assign unused_lo = addr_i[1:0];

    always_comb begin
        win_match = (tag == BASE_ADDR) && !aen_i;
        dport_o   = !dport_cs_n_i;
        if (dport_o) begin
            // window decode bypassed: fixed data register, full word
            hit_o = 1'b1;
            idx_o = DATA_IDX;
        end else begin
            hit_o = win_match;
            idx_o = addr_i[IDX_LSB +: IDX_W];
        end
    end
endmodule

// File: rtl/hbd_lane_steer.sv
module hbd_lane_steer
    import hbd_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             half_sel_i,
    input  logic             hit_i,
    input  logic             dport_i,
    input  logic [3:0]       be_n_i,
    input  logic [BUS_W-1:0] host_wdata_i,
    input  logic [WORD_W-1:0] int_rdata_i,
    output lane_t            stb_o,
    output logic [WORD_W-1:0] int_wdata_o,
    output logic [BUS_W-1:0] host_rdata_o
);
    localparam int HALF_W = WORD_W / 2;

    generate
        if (BUS_W == WORD_W) begin : g_full
            logic unused_half;
            assign unused_half = half_sel_i;
            always_comb begin
                if (dport_i)    stb_o = '1;
                else if (hit_i) stb_o = ~be_n_i;
                else            stb_o = '0;
                int_wdata_o  = host_wdata_i;
                host_rdata_o = int_rdata_i;
            end
        end else begin : g_half
            logic [1:0] unused_be_hi;
            assign unused_be_hi = be_n_i[3:2];
            always_comb begin
                if (dport_i)    stb_o = '1;
                else if (hit_i) stb_o = half_lanes(half_sel_i, ~be_n_i[1:0]);
                else            stb_o = '0;
                int_wdata_o  = {host_wdata_i, host_wdata_i};
                host_rdata_o = half_sel_i ? int_rdata_i[WORD_W-1:HALF_W]
                                          : int_rdata_i[HALF_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/host_addr_decoder.sv
module host_addr_decoder
    import hbd_pkg::*;
#(
    parameter int               AW        = 16,
    parameter int               BUS_W     = 32,
    parameter bit               USE_LATCH = 1'b1,
    parameter logic [AW-5:0]    BASE_ADDR = 12'h030,
    parameter logic [IDX_W-1:0] DATA_IDX  = 2'd3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    host_addr,
    input  logic             aen,
    input  logic             ads_n,
    input  logic             dport_cs_n,
    input  logic [3:0]       be_n,
    input  logic [BUS_W-1:0] host_wdata,
    input  logic [31:0]      int_rdata,
    output logic [AW-1:0]    lat_addr,
    output logic             dev_hit,
    output logic             dport_acc,
    output logic [1:0]       reg_idx,
    output logic [3:0]       lane_stb,
    output logic [31:0]      int_wdata,
    output logic [BUS_W-1:0] host_rdata
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic              hit;
        logic              dport;
        idx_t              idx;
        lane_t             stb;
        logic [WORD_W-1:0] wdata;
        logic [BUS_W-1:0]  rdata;
    } out_t;

    logic [AW-1:0]     eff_addr;
    logic              dec_hit, dec_dport;
    idx_t              dec_idx;
    lane_t             st_stb;
    logic [WORD_W-1:0] st_wdata;
    logic [BUS_W-1:0]  st_rdata;
    out_t              out_d, out_q;

    hbd_addr_latch #(.AW(AW), .USE_LATCH(USE_LATCH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (host_addr),
        .ads_n_i (ads_n),
        .addr_o  (eff_addr)
    );

    hbd_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR), .DATA_IDX(DATA_IDX)) u_decode (
        .addr_i       (eff_addr),
        .aen_i        (aen),
        .dport_cs_n_i (dport_cs_n),
        .hit_o        (dec_hit),
        .dport_o      (dec_dport),
        .idx_o        (dec_idx)
    );

    hbd_lane_steer #(.BUS_W(BUS_W)) u_steer (
        .half_sel_i   (eff_addr[1]),
        .hit_i        (dec_hit),
        .dport_i      (dec_dport),
        .be_n_i       (be_n),
        .host_wdata_i (host_wdata),
        .int_rdata_i  (int_rdata),
        .stb_o        (st_stb),
        .int_wdata_o  (st_wdata),
        .host_rdata_o (st_rdata)
    );

    always_comb begin
        out_d       = out_q;
        out_d.addr  = eff_addr;
        out_d.hit   = dec_hit;
        out_d.dport = dec_dport;
        out_d.idx   = dec_idx;
        out_d.stb   = st_stb;
        out_d.wdata = st_wdata;
        out_d.rdata = st_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign lat_addr   = out_q.addr;
    assign dev_hit    = out_q.hit;
    assign dport_acc  = out_q.dport;
    assign reg_idx    = out_q.idx;
    assign lane_stb   = out_q.stb;
    assign int_wdata  = out_q.wdata;
    assign host_rdata = out_q.rdata;

    AST_DPORT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        !dport_cs_n |=> (dev_hit && dport_acc && reg_idx == DATA_IDX)); // R4
    AST_DPORT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !dport_cs_n |=> (lane_stb == 4'hF)); // R5
    AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_hit |-> (lane_stb == 4'h0)); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!dev_hit && !dport_acc && lane_stb == 4'h0)); // R1

    generate
        if (BUS_W != WORD_W) begin : g_half_chk
            AST_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
                (dev_hit && !dport_acc) |-> (lane_stb[3:2] == 2'b00 || lane_stb[1:0] == 2'b00)); // R9
        end
    endgenerate
endmodule

// File: tb/host_addr_decoder_bench.sv
module host_addr_decoder_bench;
    localparam logic [11:0] BASE = 12'h030;
    localparam logic [1:0]  DIDX = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        aen = 1'b1;
    logic        ads_n = 1'b1;
    logic        dport_cs_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] host_wdata = '0;
    logic [31:0] int_rdata = '0;

    logic [15:0] lat_addr, lat_addr_h;
    logic        dev_hit, dev_hit_h, dport_acc, dport_acc_h;
    logic [1:0]  reg_idx, reg_idx_h;
    logic [3:0]  lane_stb, lane_stb_h;
    logic [31:0] int_wdata, int_wdata_h;
    logic [31:0] host_rdata;
    logic [15:0] host_rdata_h;

    int errors = 0;
    int checks = 0;
    logic [15:0] held = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    host_addr_decoder #(.BUS_W(32), .BASE_ADDR(BASE), .DATA_IDX(DIDX)) u_host_addr_decoder (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .aen(aen), .ads_n(ads_n),
        .dport_cs_n(dport_cs_n), .be_n(be_n), .host_wdata(host_wdata), .int_rdata(int_rdata),
        .lat_addr(lat_addr), .dev_hit(dev_hit), .dport_acc(dport_acc), .reg_idx(reg_idx),
        .lane_stb(lane_stb), .int_wdata(int_wdata), .host_rdata(host_rdata)
    );

    host_addr_decoder #(.BUS_W(16), .BASE_ADDR(BASE), .DATA_IDX(DIDX)) u_host_addr_decoder_n16 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .aen(aen), .ads_n(ads_n),
        .dport_cs_n(dport_cs_n), .be_n(be_n), .host_wdata(host_wdata[15:0]), .int_rdata(int_rdata),
        .lat_addr(lat_addr_h), .dev_hit(dev_hit_h), .dport_acc(dport_acc_h), .reg_idx(reg_idx_h),
        .lane_stb(lane_stb_h), .int_wdata(int_wdata_h), .host_rdata(host_rdata_h)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_stb32(input logic dp, input logic hit, input logic [3:0] b);
        if (dp) return 4'hF;
        if (hit) return ~b;
        return 4'h0;
    endfunction

    function automatic logic [3:0] exp_stb16(input logic dp, input logic hit, input logic up, input logic [3:0] b);
        if (dp) return 4'hF;
        if (!hit) return 4'h0;
        return up ? {~b[1:0], 2'b00} : {2'b00, ~b[1:0]};
    endfunction

    // apply inputs on a falling edge, compare on the next falling edge
    task automatic step(input logic [15:0] a, input logic ae, input logic as, input logic cs,
                        input logic [3:0] b, input logic [31:0] wd, input logic [31:0] rd);
        logic [15:0] eff;
        logic dp, hit;
        logic [1:0] idx;
        host_addr = a; aen = ae; ads_n = as; dport_cs_n = cs; be_n = b;
        host_wdata = wd; int_rdata = rd;
        eff = as ? held : a;
        dp  = !cs;
        hit = dp || ((eff[15:4] == BASE) && !ae);
        idx = dp ? DIDX : eff[3:2];
        @(posedge clk);
        @(negedge clk);
        check(as ? "R7 lat_addr" : "R6 lat_addr", {16'h0, lat_addr}, {16'h0, eff});
        check("R10 lat_addr_n16", {16'h0, lat_addr_h}, {16'h0, eff});
        check(dp ? "R4 dev_hit" : "R2 dev_hit", {31'h0, dev_hit}, {31'h0, hit});
        check("R4 dport_acc", {31'h0, dport_acc}, {31'h0, dp});
        if (hit) check(dp ? "R4 reg_idx" : "R2 reg_idx", {30'h0, reg_idx}, {30'h0, idx});
        check(dp ? "R5 lane_stb" : (hit ? "R8 lane_stb" : "R3 lane_stb"),
              {28'h0, lane_stb}, {28'h0, exp_stb32(dp, hit, b)});
        check(dp ? "R5 lane_stb_n16" : (hit ? "R9 lane_stb_n16" : "R3 lane_stb_n16"),
              {28'h0, lane_stb_h}, {28'h0, exp_stb16(dp, hit, eff[1], b)});
        check("R8 int_wdata", int_wdata, wd);
        check("R8 host_rdata", host_rdata, rd);
        check("R9 int_wdata_n16", int_wdata_h, {wd[15:0], wd[15:0]});
        check("R9 host_rdata_n16", {16'h0, host_rdata_h}, {16'h0, eff[1] ? rd[31:16] : rd[15:0]});
        if (!as) held = a;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 dev_hit", {31'h0, dev_hit}, 32'h0);
        check("R1 lane_stb", {28'h0, lane_stb}, 32'h0);
        check("R1 int_wdata", int_wdata, 32'h0);
        check("R1 lat_addr", {16'h0, lat_addr}, 32'h0);
        rst_n = 1'b1;

        // directed: hit with latch transparent, word half 0 and 1
        step(16'h0304, 1'b0, 1'b0, 1'b1, 4'b1100, 32'hA5A5_1234, 32'hDEAD_BEEF);
        step(16'h030E, 1'b0, 1'b0, 1'b1, 4'b0110, 32'h0000_5678, 32'hCAFE_F00D);
        // R7: strobe high, address wanders off, held address still hits
        step(16'hFFF0, 1'b0, 1'b1, 1'b1, 4'b0000, 32'h1111_2222, 32'h3333_4444);
        step(16'h0000, 1'b0, 1'b1, 1'b1, 4'b1110, 32'h5555_6666, 32'h7777_8888);
        // R3: aen high blocks the hit
        step(16'h0308, 1'b1, 1'b0, 1'b1, 4'b0000, 32'h9, 32'hA);
        // R3: base mismatch
        step(16'h0408, 1'b0, 1'b0, 1'b1, 4'b0000, 32'hB, 32'hC);
        // R4/R5: data port with all byte enables inactive and miss address
        step(16'h1234, 1'b1, 1'b0, 1'b0, 4'b1111, 32'hD, 32'hE);
        step(16'h0306, 1'b0, 1'b1, 1'b0, 4'b1010, 32'hF, 32'h10);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = 16'($urandom());
            if ($urandom_range(1, 0) == 1) a[15:4] = BASE;
            step(a, ($urandom_range(3, 0) == 0), ($urandom_range(2, 0) == 0),
                 ($urandom_range(4, 0) != 0), 4'($urandom()), $urandom(), $urandom());
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule